// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block condenses the interrupt sources of a UART into a single interrupt line and an 8-bit identification value that software reads to find out why it was interrupted. Four sources are considered: a pending receive line-status error, receive data reaching a programmable level, a receive character timeout, and the transmit holding register going empty. Each source has an enable bit. When several sources are active at once, a fixed priority picks the one that is reported.

The receive FIFO level is compared against a threshold chosen by a 2-bit trigger select. The threshold comes from one of two tables: one for a 16-entry FIFO and one for a 64-entry FIFO. A character-time strobe drives a small counter that detects receive data left sitting in the FIFO. The transmit-empty source is an edge-set, event-cleared flag. It is dropped by a transmit write, or by a read of the identification value while that value reports transmit-empty. The FIFO storage and the register decode sit outside this block and reach it as plain level and strobe inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset with all inputs low, `iid_o` is 0x01 and `irq_o` is 0.
- R2: `iid_o[3:0]` uses these codes: 0x1 for nothing pending, 0x6 for line status, 0x4 for data ready, 0xC for character timeout and 0x2 for transmit empty. `iid_o[6:4]` are 0. `irq_o` is 1 exactly when the code is not 0x1.
- R3: `ier_i[0]` enables both data ready and character timeout. `ier_i[1]` enables transmit empty. `ier_i[2]` enables line status. A disabled source never shows in the code.
- R4: When several sources are active, the reported code follows this order, highest first: line status (0x6), data ready (0x4), timeout (0xC), transmit empty (0x2).
- R5: With FIFO mode on and `deep_fifo_i`=0, trigger select 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14. Data ready is active when `rx_level_i` is at or above the threshold. The result follows the inputs in the same cycle.
- R6: With FIFO mode on and `deep_fifo_i`=1, trigger select 0, 1, 2 and 3 give thresholds of 1, 16, 48 and 56.
- R7: With FIFO mode off, data ready is active whenever `rx_level_i` is nonzero, whatever the trigger select.
- R8: In FIFO mode with a nonzero level, the timeout source sets at the clock edge that takes the 4th `char_tick_i` strobe with no `rx_push_i` or `rx_pop_i` in between. It clears at the edge that takes a push or a pop, or when the level is zero.
- R9: The transmit-empty source sets on the edge where (`thr_empty_i` AND `ier_i[1]`) goes from 0 to 1. It clears at the edge that takes `thr_write_i`, or when `thr_empty_i` is low.
- R10: An `iid_read_i` strobe clears the transmit-empty source only when the code read in that cycle is 0x2. A read that reports another code leaves the source pending.
- R11: `iid_o[7]` equals `fifo_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO mode enable |
| deep_fifo_i | input | 1 | 1 selects the 64-entry threshold table |
| trig_sel_i | input | 2 | Receive trigger select |
| rx_level_i | input | LVL_W (7) | Receive FIFO fill level |
| rx_push_i | input | 1 | A character entered the receive FIFO |
| rx_pop_i | input | 1 | A character was read from the receive FIFO |
| char_tick_i | input | 1 | One strobe per character time |
| line_err_i | input | 1 | Line-status error pending |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| thr_write_i | input | 1 | Transmit register write strobe |
| iid_read_i | input | 1 | Identification value read strobe |
| ier_i | input | 3 | Per-source enable bits |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Identification value |

## Verification
The threshold comparison and the priority encoder are combinational, so a wrong table entry or a wrong ordering shows in `iid_o` in the same cycle that the level or source changes. A timeout counter that drifts shows as code 0xC one strobe too early or too late, and a flag that fails to clear keeps 0xC visible in the cycle after a push or pop. A stuck transmit-empty flag shows as a lingering 0x2 in the cycle after a transmit write or an acknowledging read. A flag that clears on the wrong read drops 0x2 after a read that reported a higher-priority code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_NONE  = 4'h1,
    IID_LSTAT = 4'h6,
    IID_RXRDY = 4'h4,
    IID_RXTMO = 4'hC,
    IID_TXEMP = 4'h2
  } iid_code_e;

  // Receive trigger threshold, scaled from the FIFO depth of the selected table
  function automatic int unsigned trig_threshold(input logic deep,
                                                 input logic [1:0] sel,
                                                 input int unsigned depth);
    int unsigned t;
    case (sel)
      2'd0:    t = 1;
      2'd1:    t = depth / 4;
      2'd2:    t = deep ? (3 * depth) / 4 : depth / 2;
      default: t = deep ? depth - 8 : depth - 2;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int unsigned SMALL_DEPTH = 16,
  parameter int unsigned LARGE_DEPTH = 64,
  parameter int unsigned LVL_W       = 7
) (
  input  logic             fifo_en_i,
  input  logic             deep_fifo_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic             rx_ready_o
);
  localparam int unsigned NUM_SEL = 4;

  logic [LVL_W-1:0] thr_small [NUM_SEL];
  logic [LVL_W-1:0] thr_large [NUM_SEL];
  logic [LVL_W-1:0] thr_sel;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_thr
    assign thr_small[g] = LVL_W'(uart_irq_pkg::trig_threshold(1'b0, 2'(g), SMALL_DEPTH));
    assign thr_large[g] = LVL_W'(uart_irq_pkg::trig_threshold(1'b1, 2'(g), LARGE_DEPTH));
  end

  always_comb begin
    thr_sel    = deep_fifo_i ? thr_large[trig_sel_i] : thr_small[trig_sel_i];
    rx_ready_o = fifo_en_i ? (rx_level_i >= thr_sel) : (rx_level_i != '0);
  end

endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int unsigned TMO_CHARS = 4,
  parameter int unsigned LVL_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             char_tick_i,
  output logic             tmo_o
);
  localparam int unsigned CNT_W = $clog2(TMO_CHARS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tmo_q;
  logic             restart;

  assign restart = !fifo_en_i || (rx_level_i == '0) || rx_push_i || rx_pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (char_tick_i && !tmo_q) begin
      if (cnt_q == CNT_W'(TMO_CHARS - 1)) tmo_q <= 1'b1;
      else                                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo_o = tmo_q;

  assert_tmo_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i || rx_pop_i) |=> !tmo_q);

  assert_tmo_needs_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_q) |-> $past(char_tick_i));

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic txe_en_i,
  input  logic thr_write_i,
  input  logic ack_i,
  output logic pend_o
);
  logic armed, armed_q, pend_q;

  assign armed = thr_empty_i && txe_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      armed_q <= armed;
      if (thr_write_i || ack_i || !thr_empty_i) pend_q <= 1'b0;
      else if (armed && !armed_q)               pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  assert_txe_write_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_write_i |=> !pend_q);

  assert_txe_set_when_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(thr_empty_i));

  assert_txe_ack_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !pend_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic      lstat_i,
  input  logic      rxrdy_i,
  input  logic      rxtmo_i,
  input  logic      txemp_i,
  input  logic [2:0] ier_i,
  output iid_code_e code_o
);
  always_comb begin
    if      (lstat_i && ier_i[2]) code_o = IID_LSTAT;
    else if (rxrdy_i && ier_i[0]) code_o = IID_RXRDY;
    else if (rxtmo_i && ier_i[0]) code_o = IID_RXTMO;
    else if (txemp_i && ier_i[1]) code_o = IID_TXEMP;
    else                          code_o = IID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int unsigned SMALL_DEPTH = 16,
  parameter  int unsigned LARGE_DEPTH = 64,
  parameter  int unsigned TMO_CHARS   = 4,
  localparam int unsigned LVL_W       = $clog2(LARGE_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             deep_fifo_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             char_tick_i,
  input  logic             line_err_i,
  input  logic             thr_empty_i,
  input  logic             thr_write_i,
  input  logic             iid_read_i,
  input  logic [2:0]       ier_i,
  output logic             irq_o,
  output logic [7:0]       iid_o
);
  logic      rx_ready, rx_tmo, txe_pend, txe_ack;
  iid_code_e code;

  uart_irq_trig #(
    .SMALL_DEPTH(SMALL_DEPTH),
    .LARGE_DEPTH(LARGE_DEPTH),
    .LVL_W      (LVL_W)
  ) u_trig (
    .fifo_en_i  (fifo_en_i),
    .deep_fifo_i(deep_fifo_i),
    .trig_sel_i (trig_sel_i),
    .rx_level_i (rx_level_i),
    .rx_ready_o (rx_ready)
  );

  uart_irq_tmo #(
    .TMO_CHARS(TMO_CHARS),
    .LVL_W    (LVL_W)
  ) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .rx_level_i (rx_level_i),
    .rx_push_i  (rx_push_i),
    .rx_pop_i   (rx_pop_i),
    .char_tick_i(char_tick_i),
    .tmo_o      (rx_tmo)
  );

  // the flag is acknowledged only by a read that reports it
  assign txe_ack = iid_read_i && (code == IID_TXEMP);

  uart_irq_thre u_thre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thr_empty_i(thr_empty_i),
    .txe_en_i   (ier_i[1]),
    .thr_write_i(thr_write_i),
    .ack_i      (txe_ack),
    .pend_o     (txe_pend)
  );

  uart_irq_prio u_prio (
    .lstat_i(line_err_i),
    .rxrdy_i(rx_ready),
    .rxtmo_i(rx_tmo),
    .txemp_i(txe_pend),
    .ier_i  (ier_i),
    .code_o (code)
  );

  assign iid_o = {fifo_en_i, 3'b000, code};
  assign irq_o = (code != IID_NONE);

  assert_lstat_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_err_i && ier_i[2]) |-> (iid_o[3:0] == 4'h6));

  assert_all_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 3'b000) |-> !irq_o);

  assert_empty_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |-> (iid_o[3:0] != 4'h4));

endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/100ps
module tb_uart_irq_ident;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en, deep, push, pop, tick, lerr, thr_empty, thr_wr, iid_rd;
  logic [1:0] sel;
  logic [6:0] level;
  logic [2:0] ier;
  logic       irq;
  logic [7:0] iid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] iid;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  uart_irq_ident dut (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .deep_fifo_i(deep),
    .trig_sel_i(sel), .rx_level_i(level), .rx_push_i(push), .rx_pop_i(pop),
    .char_tick_i(tick), .line_err_i(lerr), .thr_empty_i(thr_empty),
    .thr_write_i(thr_wr), .iid_read_i(iid_rd), .ier_i(ier),
    .irq_o(irq), .iid_o(iid)
  );

  // driver: queue the expected value, let the monitor sample, move to next negedge
  task automatic chk(input logic [7:0] e_iid, input string tag);
    exp_t e;
    e.iid = e_iid;
    e.irq = (e_iid[3:0] != 4'h1);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    fifo_en = 0; deep = 0; push = 0; pop = 0; tick = 0; lerr = 0;
    thr_empty = 0; thr_wr = 0; iid_rd = 0; sel = 0; level = 0; ier = 0;
  endtask

  task automatic settle();
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      #1;
      e = exp_q.pop_front();
      checks++;
      if (iid !== e.iid || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                 e.tag, iid, irq, e.iid, e.irq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk(8'h01, "R1 reset idle");

    // R11 FIFO mode flag
    fifo_en = 1;
    chk(8'h81, "R11 fifo bit");

    // R5 small table
    ier = 3'b001;
    sel = 1; level = 3;  chk(8'h81, "R5 sel1 below");
    level = 4;           chk(8'h84, "R5 sel1 at 4");
    sel = 2; level = 7;  chk(8'h81, "R5 sel2 below");
    level = 8;           chk(8'h84, "R5 sel2 at 8");
    sel = 3; level = 13; chk(8'h81, "R5 sel3 below");
    level = 14;          chk(8'h84, "R5 sel3 at 14");
    sel = 0; level = 1;  chk(8'h84, "R5 sel0 at 1");
    level = 0;           chk(8'h81, "R5 empty");

    // R6 large table
    deep = 1;
    sel = 1; level = 15; chk(8'h81, "R6 sel1 below");
    level = 16;          chk(8'h84, "R6 sel1 at 16");
    sel = 2; level = 47; chk(8'h81, "R6 sel2 below");
    level = 48;          chk(8'h84, "R6 sel2 at 48");
    sel = 3; level = 55; chk(8'h81, "R6 sel3 below");
    level = 56;          chk(8'h84, "R6 sel3 at 56");
    sel = 0; level = 1;  chk(8'h84, "R6 sel0 at 1");

    // R7 non-FIFO mode
    fifo_en = 0; sel = 3; level = 1; chk(8'h04, "R7 nonfifo level1");
    level = 0;                       chk(8'h01, "R7 nonfifo empty");

    // R3 enables, R2 line-status code
    fifo_en = 1; sel = 3; level = 56; ier = 3'b000; chk(8'h81, "R3 ready masked");
    lerr = 1;                                       chk(8'h81, "R3 lstat masked");
    ier = 3'b100;                                   chk(8'h86, "R2 lstat code");
    // R4 ordering
    ier = 3'b111;                                   chk(8'h86, "R4 lstat over ready");
    lerr = 0;                                       chk(8'h84, "R4 ready after lstat");
    settle();

    // R8 timeout
    fifo_en = 1; sel = 3; level = 2; ier = 3'b001;
    ticks(3);            chk(8'h81, "R8 three ticks");
    ticks(1);            chk(8'h8C, "R8 fourth tick");
    level = 14;          chk(8'h84, "R4 ready over timeout");
    level = 2;           chk(8'h8C, "R8 timeout held");
    push = 1; @(negedge clk); push = 0;
                         chk(8'h81, "R8 push clears");
    ticks(4);            chk(8'h8C, "R8 rearmed");
    pop = 1; @(negedge clk); pop = 0;
                         chk(8'h81, "R8 pop clears");
    ier = 3'b000; ticks(4); chk(8'h81, "R3 timeout masked");
    ier = 3'b001;        chk(8'h8C, "R3 timeout enabled");
    level = 0; @(negedge clk); level = 2;
                         chk(8'h81, "R8 empty clears");
    settle();

    // R9 transmit empty
    fifo_en = 1; thr_empty = 1; ier = 3'b000;
    @(negedge clk);      chk(8'h81, "R9 masked no set");
    ier = 3'b010; @(negedge clk);
                         chk(8'h82, "R9 set on enable");
    thr_wr = 1;          chk(8'h82, "R9 before write edge");
    thr_wr = 0;          chk(8'h81, "R9 write clears");
    thr_empty = 0; @(negedge clk); thr_empty = 1; @(negedge clk);
                         chk(8'h82, "R9 set on empty edge");
    thr_empty = 0;       chk(8'h82, "R9 before drop edge");
                         chk(8'h81, "R9 not empty clears");
    thr_empty = 1; @(negedge clk);
                         chk(8'h82, "R9 set again");
    // R10 read acknowledge
    iid_rd = 1;          chk(8'h82, "R10 read reporting 2");
    iid_rd = 0;          chk(8'h81, "R10 read cleared");
    thr_empty = 0; @(negedge clk); thr_empty = 1; @(negedge clk);
    lerr = 1; ier = 3'b110;
    iid_rd = 1;          chk(8'h86, "R10 read reporting 6");
    iid_rd = 0; lerr = 0;
                         chk(8'h82, "R10 still pending");
    // R4 timeout over transmit empty
    ier = 3'b011; sel = 3; level = 2;
    ticks(4);            chk(8'h8C, "R4 timeout over txe");
    push = 1; @(negedge clk); push = 0;
                         chk(8'h82, "R4 txe after timeout");

    #3;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule